// File: doc/BRIEF.md
# Three-Stage Clos Circuit Switch

This block is a circuit switch for word streams, built as a three-stage Clos fabric. The fabric has `R` ingress crossbars. Each one takes `N` global inputs and drives `M` outlets, one outlet to each of the `M` middle crossbars. Each middle crossbar has one link to each of the `R` egress crossbars. Each egress crossbar takes its `M` middle links and drives `N` global outputs. Global port `p` sits on edge switch `p / N`, at local position `p mod N`. This mapping applies to both the input side and the output side.

A connection controller builds and tears down point-to-point calls. A connect request names one global input and one global output. The controller looks for a middle crossbar whose link from the input's ingress switch is idle and whose link to the output's egress switch is also idle. It picks the lowest-numbered such middle crossbar and then programs all three stages. A disconnect request names an output, releases both links of the call on that output, and clears its selections. The controller never moves existing calls. If no middle crossbar has both links free, the request is reported as blocked. When `M >= 2N-1` this cannot happen.

Requests and responses use valid/ready handshakes. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and it must be held until then. `req_ready` is high only while no request is being processed and no response is waiting. A response stays valid, with constant contents, until `rsp_ready` takes it. Only after that is the next request accepted. The data path has no handshake. The `PIPE` parameter sets the data path at build time: with `PIPE=0` it is purely combinational, and with `PIPE=1` it adds one register per stage.

Top module: `clos_switch`

## Requirements
- R1: A connected output carries the data word and valid flag of its connected input, where global port p maps to edge switch p / N, local position p mod N.
- R2: An output that is not in a call drives all-zero data with its valid flag low.
- R3: A request accepted at clock edge E produces `rsp_valid` after edge E+1. The response stays valid and unchanged while `rsp_ready` is low. After the edge that takes the response, `rsp_valid` is low and `req_ready` is high.
- R4: A connect (`req_op`=0) between an idle input and an idle output with a usable middle crossbar responds with status OK (code 0). Its `rsp_mid` is the lowest-numbered middle crossbar whose ingress link and egress link are both idle.
- R5: A connect whose input or output is already in a call responds with status ERROR (code 2) and changes no call.
- R6: A connect with no middle crossbar free on both links responds with status BLOCKED (code 1) and changes no call or link.
- R7: When M >= 2N-1, no request ever receives status BLOCKED.
- R8: A disconnect (`req_op`=1) of an output in a call responds with OK and the call's middle crossbar index, frees both links, and returns the output to the R2 state.
- R9: A disconnect of an output that is in no call responds with ERROR.
- R10: After reset there are no calls, all outputs are zero and invalid, `req_ready` is high and `rsp_valid` is low.
- R11: With PIPE=1, a change on a connected input reaches its output after exactly three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 1 | 0 connect, 1 disconnect |
| req_in | input | clog2(N*R) | Global input index (connect only) |
| req_out | input | clog2(N*R) | Global output index |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 2 | 0 OK, 1 BLOCKED, 2 ERROR |
| rsp_mid | output | clog2(M) | Middle crossbar used by the call |
| in_data | input | N*R*W | Input words, one W-bit word per global input |
| in_valid | input | N*R | Input valid flags |
| out_data | output | N*R*W | Output words |
| out_valid | output | N*R | Output valid flags |

## Verification
Requests are driven on a falling edge and accepted at the next rising edge. The bench expects `rsp_valid` to be low one falling edge later and high the falling edge after that. It then checks that the response holds for one more cycle before it raises `rsp_ready`, and it checks ready and valid one falling edge after that. The crossbar selections are written on the same edge that raises `rsp_valid`, so with `PIPE=0` the outputs are compared against the reference call table shortly after a falling edge, once the response has been taken. With `PIPE=1` the bench changes one input and expects the old word after two rising edges and the new word after the third.

// File: rtl/clos_pkg.sv
package clos_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BLOCKED = 2'd1,
    ST_ERROR   = 2'd2
  } rsp_status_e;

  localparam logic OP_CONNECT = 1'b0;
  localparam logic OP_RELEASE = 1'b1;

  // index width for a set of n items, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/clos_xbar.sv
module clos_xbar #(
  parameter int NI  = 2,
  parameter int NO  = 2,
  parameter int W   = 8,
  parameter int REG = 0,
  parameter int SW  = clos_pkg::idx_w(NI)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NI-1:0][W-1:0]   in_data,
  input  logic [NI-1:0]          in_vld,
  input  logic [NO-1:0][SW-1:0]  sel,
  input  logic [NO-1:0]          en,
  output logic [NO-1:0][W-1:0]   out_data,
  output logic [NO-1:0]          out_vld
);
  logic [NO-1:0][W-1:0] mux_d;
  logic [NO-1:0]        mux_v;

  for (genvar o = 0; o < NO; o++) begin : g_out
    always_comb begin
      mux_d[o] = '0;
      mux_v[o] = 1'b0;
      if (en[o]) begin
        mux_d[o] = in_data[sel[o]];
        mux_v[o] = in_vld[sel[o]];
      end
    end

    if (REG != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_data[o] <= '0;
          out_vld[o]  <= 1'b0;
        end else begin
          out_data[o] <= mux_d[o];
          out_vld[o]  <= mux_v[o];
        end
      end
      // R2: a disabled outlet is idle one stage later
      a_r2_idle_outlet_reg: assert property (@(posedge clk) disable iff (!rst_n)
        !en[o] |=> (!out_vld[o] && out_data[o] == '0));
    end else begin : g_comb
      assign out_data[o] = mux_d[o];
      assign out_vld[o]  = mux_v[o];
      // R2: a disabled outlet is idle
      a_r2_idle_outlet: assert property (@(posedge clk) disable iff (!rst_n)
        !en[o] |-> (!out_vld[o] && out_data[o] == '0));
    end
  end
endmodule

// File: rtl/clos_ctrl.sv
module clos_ctrl
  import clos_pkg::*;
#(
  parameter int N  = 2,
  parameter int M  = 3,
  parameter int R  = 2,
  parameter int P  = N * R,
  parameter int IW = idx_w(P),
  parameter int NW = idx_w(N),
  parameter int MW = idx_w(M),
  parameter int RW = idx_w(R)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_op,
  input  logic [IW-1:0]               req_in,
  input  logic [IW-1:0]               req_out,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [1:0]                  rsp_status,
  output logic [MW-1:0]               rsp_mid,
  output logic [R-1:0][M-1:0][NW-1:0] ing_sel,
  output logic [R-1:0][M-1:0]         ing_en,
  output logic [M-1:0][R-1:0][RW-1:0] mid_sel,
  output logic [M-1:0][R-1:0]         mid_en,
  output logic [R-1:0][N-1:0][MW-1:0] egr_sel,
  output logic [R-1:0][N-1:0]         egr_en
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_RESP} ctl_state_e;
  ctl_state_e state;

  logic          lat_op;
  logic [IW-1:0] lat_in, lat_out;

  logic [P-1:0]          in_busy, out_busy;
  logic [P-1:0][IW-1:0]  out_src;
  logic [P-1:0][MW-1:0]  out_mid;

  int ki, li, ko, lo, sk, md, pick;
  logic [M-1:0] free_mid;
  logic         found;

  always_comb begin
    ki = int'(lat_in) / N;
    li = int'(lat_in) % N;
    ko = int'(lat_out) / N;
    lo = int'(lat_out) % N;
    sk = int'(out_src[lat_out]) / N;
    md = int'(out_mid[lat_out]);
    for (int j = 0; j < M; j++) free_mid[j] = !ing_en[ki][j] && !mid_en[j][ko];
    pick  = 0;
    found = 1'b0;
    for (int j = M - 1; j >= 0; j--) begin
      if (free_mid[j]) begin
        pick  = j;
        found = 1'b1;
      end
    end
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      lat_op     <= OP_CONNECT;
      lat_in     <= '0;
      lat_out    <= '0;
      rsp_status <= ST_OK;
      rsp_mid    <= '0;
      in_busy    <= '0;
      out_busy   <= '0;
      out_src    <= '0;
      out_mid    <= '0;
      ing_sel    <= '0;
      ing_en     <= '0;
      mid_sel    <= '0;
      mid_en     <= '0;
      egr_sel    <= '0;
      egr_en     <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            lat_op  <= req_op;
            lat_in  <= req_in;
            lat_out <= req_out;
            state   <= S_EXEC;
          end
        end
        S_EXEC: begin
          state   <= S_RESP;
          rsp_mid <= '0;
          if (lat_op == OP_CONNECT) begin
            if (in_busy[lat_in] || out_busy[lat_out]) begin
              rsp_status <= ST_ERROR;
            end else if (!found) begin
              rsp_status <= ST_BLOCKED;
            end else begin
              rsp_status        <= ST_OK;
              rsp_mid           <= MW'(pick);
              in_busy[lat_in]   <= 1'b1;
              out_busy[lat_out] <= 1'b1;
              out_src[lat_out]  <= lat_in;
              out_mid[lat_out]  <= MW'(pick);
              ing_en[ki][pick]  <= 1'b1;
              ing_sel[ki][pick] <= NW'(li);
              mid_en[pick][ko]  <= 1'b1;
              mid_sel[pick][ko] <= RW'(ki);
              egr_en[ko][lo]    <= 1'b1;
              egr_sel[ko][lo]   <= MW'(pick);
            end
          end else begin
            if (!out_busy[lat_out]) begin
              rsp_status <= ST_ERROR;
            end else begin
              rsp_status                <= ST_OK;
              rsp_mid                   <= out_mid[lat_out];
              in_busy[out_src[lat_out]] <= 1'b0;
              out_busy[lat_out]         <= 1'b0;
              ing_en[sk][md]            <= 1'b0;
              ing_sel[sk][md]           <= '0;
              mid_en[md][ko]            <= 1'b0;
              mid_sel[md][ko]           <= '0;
              egr_en[ko][lo]            <= 1'b0;
              egr_sel[ko][lo]           <= '0;
            end
          end
        end
        default: begin
          if (rsp_ready) state <= S_IDLE;
        end
      endcase
    end
  end

  // R3: a response waiting for rsp_ready is held unchanged
  a_r3_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_mid)));

  // R5: a connect to a busy input is refused
  a_r5_busy_input: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EXEC && lat_op == OP_CONNECT && in_busy[lat_in]) |=> (rsp_status == ST_ERROR));

  // R8: every live call holds one ingress link and one egress-side link
  a_r8_ing_links: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ing_en) == $countones(out_busy));
  a_r8_egr_links: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mid_en) == $countones(egr_en));

  if (M >= 2 * N - 1) begin : g_nb
    // R7: strict-sense nonblocking sizing never blocks
    a_r7_never_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_status != ST_BLOCKED));
  end
endmodule

// File: rtl/clos_switch.sv
module clos_switch
  import clos_pkg::*;
#(
  parameter int N    = 2,
  parameter int M    = 3,
  parameter int R    = 2,
  parameter int W    = 8,
  parameter int PIPE = 0,
  localparam int P   = N * R,
  localparam int IW  = idx_w(P),
  localparam int MW  = idx_w(M)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_op,
  input  logic [IW-1:0]       req_in,
  input  logic [IW-1:0]       req_out,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [1:0]          rsp_status,
  output logic [MW-1:0]       rsp_mid,
  input  logic [P-1:0][W-1:0] in_data,
  input  logic [P-1:0]        in_valid,
  output logic [P-1:0][W-1:0] out_data,
  output logic [P-1:0]        out_valid
);
  localparam int NW = idx_w(N);
  localparam int RW = idx_w(R);

  logic [R-1:0][M-1:0][NW-1:0] ing_sel;
  logic [R-1:0][M-1:0]         ing_en;
  logic [M-1:0][R-1:0][RW-1:0] mid_sel;
  logic [M-1:0][R-1:0]         mid_en;
  logic [R-1:0][N-1:0][MW-1:0] egr_sel;
  logic [R-1:0][N-1:0]         egr_en;

  logic [R-1:0][N-1:0][W-1:0] ing_in_d;
  logic [R-1:0][N-1:0]        ing_in_v;
  logic [R-1:0][M-1:0][W-1:0] ing_out_d;
  logic [R-1:0][M-1:0]        ing_out_v;
  logic [M-1:0][R-1:0][W-1:0] mid_in_d, mid_out_d;
  logic [M-1:0][R-1:0]        mid_in_v, mid_out_v;
  logic [R-1:0][M-1:0][W-1:0] egr_in_d;
  logic [R-1:0][M-1:0]        egr_in_v;
  logic [R-1:0][N-1:0][W-1:0] egr_out_d;
  logic [R-1:0][N-1:0]        egr_out_v;

  clos_ctrl #(.N(N), .M(M), .R(R)) u_ctrl (
    .clk, .rst_n,
    .req_valid, .req_ready, .req_op, .req_in, .req_out,
    .rsp_valid, .rsp_ready, .rsp_status, .rsp_mid,
    .ing_sel, .ing_en, .mid_sel, .mid_en, .egr_sel, .egr_en
  );

  // edge port mapping: global port k*N+l <-> edge switch k, local l
  for (genvar k = 0; k < R; k++) begin : g_edge
    for (genvar l = 0; l < N; l++) begin : g_port
      assign ing_in_d[k][l]     = in_data[k*N+l];
      assign ing_in_v[k][l]     = in_valid[k*N+l];
      assign out_data[k*N+l]    = egr_out_d[k][l];
      assign out_valid[k*N+l]   = egr_out_v[k][l];
    end
    for (genvar j = 0; j < M; j++) begin : g_link
      assign mid_in_d[j][k] = ing_out_d[k][j];
      assign mid_in_v[j][k] = ing_out_v[k][j];
      assign egr_in_d[k][j] = mid_out_d[j][k];
      assign egr_in_v[k][j] = mid_out_v[j][k];
    end
  end

  for (genvar k = 0; k < R; k++) begin : g_ing
    clos_xbar #(.NI(N), .NO(M), .W(W), .REG(PIPE), .SW(NW)) u_xbar (
      .clk, .rst_n,
      .in_data(ing_in_d[k]), .in_vld(ing_in_v[k]),
      .sel(ing_sel[k]), .en(ing_en[k]),
      .out_data(ing_out_d[k]), .out_vld(ing_out_v[k])
    );
  end

  for (genvar j = 0; j < M; j++) begin : g_mid
    clos_xbar #(.NI(R), .NO(R), .W(W), .REG(PIPE), .SW(RW)) u_xbar (
      .clk, .rst_n,
      .in_data(mid_in_d[j]), .in_vld(mid_in_v[j]),
      .sel(mid_sel[j]), .en(mid_en[j]),
      .out_data(mid_out_d[j]), .out_vld(mid_out_v[j])
    );
  end

  for (genvar k = 0; k < R; k++) begin : g_egr
    clos_xbar #(.NI(M), .NO(N), .W(W), .REG(PIPE), .SW(MW)) u_xbar (
      .clk, .rst_n,
      .in_data(egr_in_d[k]), .in_vld(egr_in_v[k]),
      .sel(egr_sel[k]), .en(egr_en[k]),
      .out_data(egr_out_d[k]), .out_vld(egr_out_v[k])
    );
  end
endmodule

// File: tb/clos_switch_tb.sv
`timescale 1ns/1ps
module clos_switch_tb;
  localparam int N = 2, R = 2, W = 8, P = N * R;
  localparam int MA = 3;  // 2N-1, nonblocking
  localparam int MB = 2;  // N, may block

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic a_req_valid = 0, a_req_op = 0, a_rsp_ready = 0;
  logic [1:0] a_req_in = 0, a_req_out = 0;
  logic a_req_ready, a_rsp_valid;
  logic [1:0] a_rsp_status, a_rsp_mid;
  logic [P-1:0][W-1:0] a_in_data = '0, a_out_data;
  logic [P-1:0] a_in_valid = '0, a_out_valid;

  logic b_req_valid = 0, b_req_op = 0, b_rsp_ready = 0;
  logic [1:0] b_req_in = 0, b_req_out = 0;
  logic b_req_ready, b_rsp_valid;
  logic [1:0] b_rsp_status;
  logic [0:0] b_rsp_mid;
  logic [P-1:0][W-1:0] b_in_data = '0, b_out_data;
  logic [P-1:0] b_in_valid = '0, b_out_valid;

  clos_switch #(.N(N), .M(MA), .R(R), .W(W), .PIPE(0)) u_dut (
    .clk, .rst_n, .req_valid(a_req_valid), .req_ready(a_req_ready), .req_op(a_req_op),
    .req_in(a_req_in), .req_out(a_req_out), .rsp_valid(a_rsp_valid), .rsp_ready(a_rsp_ready),
    .rsp_status(a_rsp_status), .rsp_mid(a_rsp_mid), .in_data(a_in_data), .in_valid(a_in_valid),
    .out_data(a_out_data), .out_valid(a_out_valid));

  clos_switch #(.N(N), .M(MB), .R(R), .W(W), .PIPE(1)) u_dut_b (
    .clk, .rst_n, .req_valid(b_req_valid), .req_ready(b_req_ready), .req_op(b_req_op),
    .req_in(b_req_in), .req_out(b_req_out), .rsp_valid(b_rsp_valid), .rsp_ready(b_rsp_ready),
    .rsp_status(b_rsp_status), .rsp_mid(b_rsp_mid), .in_data(b_in_data), .in_valid(b_in_valid),
    .out_data(b_out_data), .out_valid(b_out_valid));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference call table for u_dut
  int  r_src[P];
  int  r_mid[P];
  bit  r_inb[P];
  bit  r_il[R][MA];
  bit  r_ml[MA][R];

  task automatic do_req(input bit b, input bit op, input int i, input int o,
                        output int st, output int md);
    @(negedge clk);
    if (!b) begin a_req_valid = 1; a_req_op = op; a_req_in = 2'(i); a_req_out = 2'(o); end
    else    begin b_req_valid = 1; b_req_op = op; b_req_in = 2'(i); b_req_out = 2'(o); end
    @(negedge clk);
    a_req_valid = 0; b_req_valid = 0;
    chk((b ? b_rsp_valid : a_rsp_valid) == 1'b0, "R3 no response yet", 1, 0);
    @(negedge clk);
    chk((b ? b_rsp_valid : a_rsp_valid) == 1'b1, "R3 response due", 0, 1);
    st = b ? int'(b_rsp_status) : int'(a_rsp_status);
    md = b ? int'(b_rsp_mid) : int'(a_rsp_mid);
    @(negedge clk);
    chk((b ? b_rsp_valid : a_rsp_valid) == 1'b1 &&
        (b ? int'(b_rsp_status) : int'(a_rsp_status)) == st, "R3 response held",
        b ? int'(b_rsp_status) : int'(a_rsp_status), st);
    if (!b) a_rsp_ready = 1; else b_rsp_ready = 1;
    @(negedge clk);
    a_rsp_ready = 0; b_rsp_ready = 0;
    chk((b ? b_rsp_valid : a_rsp_valid) == 1'b0 && (b ? b_req_ready : a_req_ready) == 1'b1,
        "R3 ready after take", int'(b ? b_req_ready : a_req_ready), 1);
  endtask

  // model-based request on u_dut
  task automatic model_req(input bit op, input int i, input int o);
    int st, md, est, emd, ki, ko;
    est = 0; emd = 0;
    ki = i / N; ko = o / N;
    if (op == 0) begin
      if (r_inb[i] || r_src[o] >= 0) est = 2;
      else begin
        est = 1;
        for (int j = MA - 1; j >= 0; j--)
          if (!r_il[ki][j] && !r_ml[j][ko]) begin est = 0; emd = j; end
      end
    end else begin
      if (r_src[o] < 0) est = 2;
      else emd = r_mid[o];
    end
    do_req(1'b0, op, i, o, st, md);
    if (op == 0) begin
      chk(st == est, (est == 2) ? "R5 connect status" : "R4 connect status", st, est);
      chk(st != 1, "R7 never blocked", st, 0);
    end else begin
      chk(st == est, (est == 2) ? "R9 release idle status" : "R8 release status", st, est);
    end
    if (est == 0) chk(md == emd, (op == 0) ? "R4 middle choice" : "R8 middle reported", md, emd);
    if (est == 0 && op == 0) begin
      r_inb[i] = 1; r_src[o] = i; r_mid[o] = emd; r_il[ki][emd] = 1; r_ml[emd][ko] = 1;
    end else if (est == 0) begin
      r_inb[r_src[o]] = 0; r_il[r_src[o] / N][emd] = 0; r_ml[emd][ko] = 0; r_src[o] = -1;
    end
  endtask

  task automatic data_check();
    @(negedge clk);
    for (int p = 0; p < P; p++) begin
      a_in_data[p]  = W'($urandom);
      a_in_valid[p] = 1'($urandom);
    end
    #1;
    for (int o = 0; o < P; o++) begin
      if (r_src[o] >= 0) begin
        chk(a_out_data[o] == a_in_data[r_src[o]], "R1 routed data",
            int'(a_out_data[o]), int'(a_in_data[r_src[o]]));
        chk(a_out_valid[o] == a_in_valid[r_src[o]], "R1 routed valid",
            int'(a_out_valid[o]), int'(a_in_valid[r_src[o]]));
      end else begin
        chk(a_out_data[o] == '0 && !a_out_valid[o], "R2 idle output zero",
            int'(a_out_data[o]), 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int st, md;
    void'($urandom(32'h5eed_c105));
    for (int p = 0; p < P; p++) begin r_src[p] = -1; r_mid[p] = 0; r_inb[p] = 0; end
    for (int k = 0; k < R; k++) for (int j = 0; j < MA; j++) begin r_il[k][j] = 0; r_ml[j][k] = 0; end

    repeat (3) @(negedge clk);
    a_in_data = {8'h44, 8'h33, 8'h22, 8'h11}; a_in_valid = '1;
    #1;
    // R10 reset state
    chk(a_req_ready == 1'b1 && a_rsp_valid == 1'b0, "R10 handshake at reset", int'(a_rsp_valid), 0);
    chk(a_out_data == '0 && a_out_valid == '0, "R10 outputs idle", int'(a_out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: lowest free middle
    model_req(0, 0, 3);  // R4: mid 0
    model_req(0, 1, 2);  // R4: ingress 0 has mid 0 busy -> mid 1
    model_req(0, 0, 1);  // R5: input busy
    model_req(0, 2, 3);  // R5: output busy
    model_req(1, 0, 0);  // R9: idle output
    data_check();
    model_req(1, 0, 3);  // R8
    data_check();        // R8/R2: output 3 back to zero

    // random connect/disconnect against the model
    for (int t = 0; t < 300; t++) begin
      model_req(1'($urandom_range(0, 1)), $urandom_range(0, P - 1), $urandom_range(0, P - 1));
      if (t % 10 == 9) data_check();
    end

    // blocking fabric with pipelined data path
    do_req(1, 0, 0, 0, st, md); chk(st == 0 && md == 0, "R4 blk first call", md, 0);
    do_req(1, 0, 2, 2, st, md); chk(st == 0 && md == 0, "R4 blk second call", md, 0);
    do_req(1, 0, 3, 3, st, md); chk(st == 0 && md == 1, "R4 blk third call", md, 1);
    do_req(1, 1, 0, 2, st, md); chk(st == 0 && md == 0, "R8 blk release", md, 0);
    do_req(1, 0, 1, 2, st, md); chk(st == 1, "R6 blocked status", st, 1);
    do_req(1, 0, 1, 1, st, md); chk(st == 0 && md == 1, "R6 blocked call left input free", md, 1);

    @(negedge clk);
    b_in_data = {8'hD4, 8'hC3, 8'hB2, 8'hA1}; b_in_valid = '1;
    repeat (4) @(negedge clk);
    chk(b_out_data[1] == 8'hB2 && b_out_valid[1], "R11 steady word", int'(b_out_data[1]), 'hB2);
    chk(b_out_data[2] == '0 && !b_out_valid[2], "R2 blk idle output", int'(b_out_data[2]), 0);
    b_in_data[1] = 8'h5A;
    repeat (2) @(negedge clk);
    chk(b_out_data[1] == 8'hB2, "R11 old word after two edges", int'(b_out_data[1]), 'hB2);
    @(negedge clk);
    chk(b_out_data[1] == 8'h5A, "R11 new word after three edges", int'(b_out_data[1]), 'h5A);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule